// File: doc/BRIEF.md
# Secured-Region Read Sequencer for Parallel NOR Flash

This block fetches bytes from the small one-time-programmable secured area of a bank of NOR flash devices. The devices share one command and read bus. Software sees a single linear space in which every device owns eight bytes. A request gives a start address and a byte count. The sequencer splits the range into one burst per device and never lets a burst run past the end of a device's eight bytes. It stops when the device index goes past the number of installed devices.

Each burst has the same steps. The sequencer waits until the target device reports ready. It then issues a three-write unlock-and-enter sequence, reads the requested bytes one strobe at a time, and issues a four-write exit sequence that returns the device to normal array reads. Command and read strobes last one cycle each, and a configurable number of idle cycles separates any two strobes. Every byte read is passed out one cycle after its strobe. When the whole request has been handled, a done pulse reports how many bytes were actually delivered.

Top module: `secreg_rd_seq`

## Requirements
- R1: While reset is asserted and after it is released with no request, no strobe is issued and `done_o` and `out_vld_o` are 0.
- R2: Address decode: device = `req_addr_i >> 3` and offset = `req_addr_i & 7`. A read strobe drives `bus_addr_o = {device[IDX_W-1:0], offset zero-extended to DEV_AW bits}`.
- R3: Bytes are read in ascending address order. The first device's burst length is min(remaining, 8 - offset). Every later device starts at offset 0.
- R4: Before the first read of a burst, exactly three command writes are issued in this order: 0xAA to unlock address 1, 0x55 to unlock address 2, 0x88 to unlock address 1. Each command address is `{device index, unlock address}`.
- R5: After the last read of a burst, exactly four command writes are issued in this order: 0xAA to unlock address 1, 0x55 to unlock address 2, 0x90 to unlock address 1, 0x00 to unlock address 1.
- R6: No strobe for a device is issued until its bit of `dev_ready_i` is 1.
- R7: Splitting stops when the device index reaches `N_DEV`. `xfer_len_o` at done equals the number of bytes actually read. A start beyond the last device reads nothing.
- R8: Every strobe lasts one cycle. `cmd_we_o` and `rd_en_o` are never high together. Any two strobes are separated by at least `GAP_CYC` idle cycles.
- R9: In the cycle after each read strobe, `out_vld_o` is 1 and `out_data_o` holds the `rd_data_i` value sampled during that strobe.
- R10: `done_o` is a single-cycle pulse issued after the final exit sequence. A zero-length request produces done with `xfer_len_o = 0` and no strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start pulse, sampled while idle |
| req_addr_i | input | ADDR_W | Linear start address in secured space |
| req_len_i | input | LEN_W | Byte count |
| done_o | output | 1 | Request complete, one cycle |
| xfer_len_o | output | LEN_W | Bytes delivered by the last request |
| dev_ready_i | input | N_DEV | Per-device ready flag |
| bus_addr_o | output | IDX_W+DEV_AW | Bus address, device index in the top bits |
| cmd_we_o | output | 1 | Command write strobe |
| cmd_data_o | output | 8 | Command byte |
| rd_en_o | output | 1 | Read strobe |
| rd_data_i | input | 8 | Read data, valid during the read strobe |
| out_vld_o | output | 1 | Output byte valid |
| out_data_o | output | 8 | Output byte |

## Verification
The bench aims at ranges that start mid-region and then spill into the next device. A sequencer that did not clip the first burst would read past offset 7 and alias into another region, and one that kept the offset for the next device would skip that device's first bytes. It also sends ranges that run off the last device or start beyond it. A design that did not stop at the device count would issue strobes to a device index that does not exist, or would report the requested length instead of the delivered one. Other cases hold one device not ready, use zero length, and run with a gap of two cycles. These catch strobes issued too early, packed too tightly, or given in the wrong command order.

// File: rtl/secreg_pkg.sv
package secreg_pkg;
  localparam int REGION_SHIFT = 3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SPLIT, ST_WAIT, ST_ENTRY, ST_READ, ST_EXIT, ST_DONE
  } seq_state_e;

  typedef enum logic {
    SEL_UNLOCK1,
    SEL_UNLOCK2
  } unlock_sel_e;
endpackage

// File: rtl/secreg_splitter.sv
module secreg_splitter #(
  parameter int N_DEV = 4,
  parameter int DEV_W = 5,
  parameter int LEN_W = 8
) (
  input  logic [DEV_W:0]   dev_i,
  input  logic [2:0]       ofs_i,
  input  logic [LEN_W-1:0] rem_i,
  output logic             stop_o,
  output logic [3:0]       chunk_o
);
  localparam logic [DEV_W:0] LAST_DEV = (DEV_W + 1)'(N_DEV);

  logic [3:0] room;

  always_comb begin
    room    = 4'd8 - {1'b0, ofs_i};
    stop_o  = (rem_i == '0) || (dev_i >= LAST_DEV);
    chunk_o = (rem_i < LEN_W'(room)) ? rem_i[3:0] : room;
  end
endmodule

// File: rtl/secreg_cmd_rom.sv
module secreg_cmd_rom
  import secreg_pkg::*;
(
  input  logic        exit_i,
  input  logic [2:0]  step_i,
  output logic [7:0]  data_o,
  output unlock_sel_e sel_o,
  output logic        last_o
);
  always_comb begin
    data_o = 8'h00;
    sel_o  = SEL_UNLOCK1;
    last_o = 1'b0;
    unique case (step_i)
      3'd0: data_o = 8'hAA;
      3'd1: begin data_o = 8'h55; sel_o = SEL_UNLOCK2; end
      3'd2: begin data_o = exit_i ? 8'h90 : 8'h88; last_o = !exit_i; end
      3'd3: begin data_o = 8'h00; last_o = 1'b1; end
      default: last_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/secreg_gap_timer.sv
module secreg_gap_timer #(
  parameter int GAP_CYC = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic free_o
);
  localparam int GW = (GAP_CYC > 0) ? $clog2(GAP_CYC + 1) : 1;

  logic [GW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (fire_i)      cnt_q <= GW'(GAP_CYC);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign free_o = (cnt_q == '0);
endmodule

// File: rtl/secreg_rd_seq.sv
module secreg_rd_seq
  import secreg_pkg::*;
#(
  parameter int N_DEV   = 4,
  parameter int ADDR_W  = 8,
  parameter int LEN_W   = 8,
  parameter int DEV_AW  = 12,
  parameter logic [DEV_AW-1:0] UNLOCK1 = 'h555,
  parameter logic [DEV_AW-1:0] UNLOCK2 = 'h2AA,
  parameter int GAP_CYC = 1,
  localparam int IDX_W  = $clog2(N_DEV),
  localparam int BUS_AW = IDX_W + DEV_AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  output logic              done_o,
  output logic [LEN_W-1:0]  xfer_len_o,
  input  logic [N_DEV-1:0]  dev_ready_i,
  output logic [BUS_AW-1:0] bus_addr_o,
  output logic              cmd_we_o,
  output logic [7:0]        cmd_data_o,
  output logic              rd_en_o,
  input  logic [7:0]        rd_data_i,
  output logic              out_vld_o,
  output logic [7:0]        out_data_o
);
  localparam int DEV_W = ADDR_W - REGION_SHIFT;

  seq_state_e       state_q;
  logic [DEV_W:0]   dev_q;
  logic [2:0]       ofs_q;
  logic [2:0]       step_q;
  logic [3:0]       chunk_q;
  logic [LEN_W-1:0] rem_q;
  logic [LEN_W-1:0] cnt_q;
  logic             out_vld_q;
  logic [7:0]       out_data_q;

  logic             stop;
  logic [3:0]       chunk;
  logic [7:0]       rom_data;
  unlock_sel_e      rom_sel;
  logic             rom_last;
  logic             gap_free;
  logic             bus_phase;
  logic             fire;
  logic [IDX_W-1:0] dev_idx;
  logic [2:0]       rd_ofs;
  logic             burst_end;

  secreg_splitter #(.N_DEV(N_DEV), .DEV_W(DEV_W), .LEN_W(LEN_W)) u_split (
    .dev_i  (dev_q),
    .ofs_i  (ofs_q),
    .rem_i  (rem_q),
    .stop_o (stop),
    .chunk_o(chunk)
  );

  secreg_cmd_rom u_rom (
    .exit_i(state_q == ST_EXIT),
    .step_i(step_q),
    .data_o(rom_data),
    .sel_o (rom_sel),
    .last_o(rom_last)
  );

  secreg_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .fire_i(fire),
    .free_o(gap_free)
  );

  assign dev_idx   = dev_q[IDX_W-1:0];
  assign rd_ofs    = ofs_q + step_q;
  assign burst_end = (({1'b0, step_q} + 4'd1) == chunk_q);
  assign bus_phase = (state_q == ST_ENTRY) || (state_q == ST_READ) || (state_q == ST_EXIT);
  assign fire      = bus_phase && gap_free;

  assign rd_en_o    = fire && (state_q == ST_READ);
  assign cmd_we_o   = fire && (state_q != ST_READ);
  assign cmd_data_o = cmd_we_o ? rom_data : 8'h00;

  always_comb begin
    if (state_q == ST_READ)
      bus_addr_o = {dev_idx, DEV_AW'(rd_ofs)};
    else
      bus_addr_o = {dev_idx, (rom_sel == SEL_UNLOCK1) ? UNLOCK1 : UNLOCK2};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      dev_q   <= '0;
      ofs_q   <= '0;
      step_q  <= '0;
      chunk_q <= '0;
      rem_q   <= '0;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          dev_q   <= {1'b0, req_addr_i[ADDR_W-1:REGION_SHIFT]};
          ofs_q   <= req_addr_i[2:0];
          rem_q   <= req_len_i;
          cnt_q   <= '0;
          state_q <= ST_SPLIT;
        end
        ST_SPLIT: begin
          if (stop) state_q <= ST_DONE;
          else begin
            chunk_q <= chunk;
            step_q  <= '0;
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: if (dev_ready_i[dev_idx]) state_q <= ST_ENTRY;
        ST_ENTRY: if (fire) begin
          if (rom_last) begin
            step_q  <= '0;
            state_q <= ST_READ;
          end else step_q <= step_q + 3'd1;
        end
        ST_READ: if (fire) begin
          if (burst_end) begin
            step_q  <= '0;
            state_q <= ST_EXIT;
          end else step_q <= step_q + 3'd1;
        end
        ST_EXIT: if (fire) begin
          if (rom_last) begin
            rem_q   <= rem_q - LEN_W'(chunk_q);
            cnt_q   <= cnt_q + LEN_W'(chunk_q);
            dev_q   <= dev_q + 1'b1;
            ofs_q   <= '0;
            step_q  <= '0;
            state_q <= ST_SPLIT;
          end else step_q <= step_q + 3'd1;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // byte is captured at the end of its read strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_vld_q  <= 1'b0;
      out_data_q <= '0;
    end else begin
      out_vld_q <= rd_en_o;
      if (rd_en_o) out_data_q <= rd_data_i;
    end
  end

  assign out_vld_o  = out_vld_q;
  assign out_data_o = out_data_q;
  assign done_o     = (state_q == ST_DONE);
  assign xfer_len_o = cnt_q;
endmodule

// File: rtl/secreg_rd_seq_chk.sv
module secreg_rd_seq_chk #(
  parameter int N_DEV   = 4,
  parameter int DEV_AW  = 12,
  parameter logic [DEV_AW-1:0] UNLOCK1 = 'h555,
  parameter logic [DEV_AW-1:0] UNLOCK2 = 'h2AA,
  parameter int GAP_CYC = 1,
  localparam int IDX_W  = $clog2(N_DEV),
  localparam int BUS_AW = IDX_W + DEV_AW
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              done_o,
  input logic [BUS_AW-1:0] bus_addr_o,
  input logic              cmd_we_o,
  input logic [7:0]        cmd_data_o,
  input logic              rd_en_o,
  input logic [7:0]        rd_data_i,
  input logic              out_vld_o,
  input logic [7:0]        out_data_o
);
  localparam int SW = $clog2(GAP_CYC + 2);

  logic [SW-1:0]     since_q;
  logic [DEV_AW-1:0] dev_ofs;
  logic              strobe;

  assign strobe  = cmd_we_o || rd_en_o;
  assign dev_ofs = bus_addr_o[DEV_AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          since_q <= SW'(GAP_CYC);
    else if (strobe)                      since_q <= '0;
    else if (since_q < SW'(GAP_CYC))      since_q <= since_q + 1'b1;
  end

  assert_bus_gap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe |-> (since_q >= SW'(GAP_CYC)));

  assert_one_strobe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_we_o && rd_en_o));

  assert_cmd_addr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_we_o |-> (dev_ofs == UNLOCK1 || dev_ofs == UNLOCK2));

  assert_cmd_code_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_we_o |-> (cmd_data_o == 8'hAA || cmd_data_o == 8'h55 || cmd_data_o == 8'h88 ||
                  cmd_data_o == 8'h90 || cmd_data_o == 8'h00));

  assert_read_in_region_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |-> (dev_ofs < DEV_AW'(8)));

  assert_out_follows_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |=> (out_vld_o && out_data_o == $past(rd_data_i)));

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind secreg_rd_seq secreg_rd_seq_chk #(
  .N_DEV(N_DEV), .DEV_AW(DEV_AW), .UNLOCK1(UNLOCK1), .UNLOCK2(UNLOCK2), .GAP_CYC(GAP_CYC)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .done_o(done_o), .bus_addr_o(bus_addr_o),
  .cmd_we_o(cmd_we_o), .cmd_data_o(cmd_data_o), .rd_en_o(rd_en_o),
  .rd_data_i(rd_data_i), .out_vld_o(out_vld_o), .out_data_o(out_data_o)
);

// File: tb/secreg_rd_seq_tb_top.sv
module secreg_rd_seq_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int TB_GAP = 2;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [7:0]  req_addr_i = '0;
  logic [7:0]  req_len_i = '0;
  logic        done_o;
  logic [7:0]  xfer_len_o;
  logic [3:0]  dev_ready_i = 4'hF;
  logic [13:0] bus_addr_o;
  logic        cmd_we_o;
  logic [7:0]  cmd_data_o;
  logic        rd_en_o;
  logic [7:0]  rd_data_i;
  logic        out_vld_o;
  logic [7:0]  out_data_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int bus_events = 0;
  int last_cyc = -1000;
  logic [23:0] exp_bus[$];
  logic [7:0]  exp_byte[$];

  always #10 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  secreg_rd_seq #(.GAP_CYC(TB_GAP)) dut_i (.*);

  function automatic logic [7:0] pat(input logic [13:0] a);
    return {2'b10, a[13:12], 1'b0, a[2:0]} ^ {a[11:8], 4'h0};
  endfunction

  assign rd_data_i = rd_en_o ? pat(bus_addr_o) : 8'h00;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares bus strobes and output bytes against the scoreboard
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (cmd_we_o || rd_en_o) begin
        logic [23:0] act;
        act = {cmd_we_o ? 2'd1 : 2'd2, cmd_data_o, bus_addr_o};
        bus_events++;
        chk(!(cmd_we_o && rd_en_o), "R8 single strobe", {30'd0, cmd_we_o, rd_en_o}, 32'd1);
        chk(cyc - last_cyc >= TB_GAP + 1, "R8 gap", cyc - last_cyc, TB_GAP + 1);
        last_cyc = cyc;
        if (exp_bus.size() == 0) chk(1'b0, "R4/R5 unexpected strobe", {8'd0, act}, 32'd0);
        else begin
          logic [23:0] e;
          e = exp_bus.pop_front();
          chk(act == e, cmd_we_o ? "R4/R5 command order" : "R2/R3 read address", {8'd0, act}, {8'd0, e});
        end
      end
      if (out_vld_o) begin
        if (exp_byte.size() == 0) chk(1'b0, "R9 unexpected byte", {24'd0, out_data_o}, 32'd0);
        else begin
          logic [7:0] b;
          b = exp_byte.pop_front();
          chk(out_data_o == b, "R9 byte data", {24'd0, out_data_o}, {24'd0, b});
        end
      end
    end
  end

  task automatic push_cmd(input int dev, input logic [11:0] ua, input logic [7:0] d);
    logic [1:0] di;
    di = 2'(dev);
    exp_bus.push_back({2'd1, d, di, ua});
  endtask

  // driver: expected strobes and bytes straight from the requirements
  task automatic plan_req(input int addr, input int len, output int total);
    int dev;
    int ofs;
    int rem;
    dev = addr >> 3;
    ofs = addr & 7;
    rem = len;
    total = 0;
    while (rem > 0 && dev < 4) begin
      int chunk;
      chunk = (rem < 8 - ofs) ? rem : 8 - ofs;
      push_cmd(dev, 12'h555, 8'hAA);
      push_cmd(dev, 12'h2AA, 8'h55);
      push_cmd(dev, 12'h555, 8'h88);
      for (int k = 0; k < chunk; k++) begin
        logic [13:0] a;
        a = {2'(dev), 12'(ofs + k)};
        exp_bus.push_back({2'd2, 8'h00, a});
        exp_byte.push_back(pat(a));
      end
      push_cmd(dev, 12'h555, 8'hAA);
      push_cmd(dev, 12'h2AA, 8'h55);
      push_cmd(dev, 12'h555, 8'h90);
      push_cmd(dev, 12'h555, 8'h00);
      rem -= chunk;
      total += chunk;
      dev++;
      ofs = 0;
    end
  endtask

  task automatic launch(input int addr, input int len);
    @(negedge clk_i);
    req_addr_i = 8'(addr);
    req_len_i  = 8'(len);
    req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  task automatic finish_req(input int total, input string tag);
    int n;
    n = 0;
    while (!done_o && n < 2000) begin
      @(negedge clk_i);
      n++;
    end
    chk(done_o, {tag, " done seen"}, {31'd0, done_o}, 32'd1);
    chk(xfer_len_o == 8'(total), {tag, " xfer_len"}, {24'd0, xfer_len_o}, total);
    @(negedge clk_i);
    chk(!done_o, "R10 done one cycle", {31'd0, done_o}, 32'd0);
    repeat (2) @(negedge clk_i);
    chk(exp_bus.size() == 0, {tag, " all strobes seen"}, exp_bus.size(), 0);
    chk(exp_byte.size() == 0, {tag, " all bytes seen"}, exp_byte.size(), 0);
  endtask

  task automatic run(input int addr, input int len, input string tag);
    int total;
    plan_req(addr, len, total);
    launch(addr, len);
    finish_req(total, tag);
  endtask

  initial begin
    #(20ns * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int ev0;
    int total;
    repeat (3) @(negedge clk_i);
    chk(!cmd_we_o && !rd_en_o && !done_o && !out_vld_o, "R1 in reset",
        {28'd0, cmd_we_o, rd_en_o, done_o, out_vld_o}, 32'd0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    chk(bus_events == 0 && !done_o && !out_vld_o, "R1 idle after reset", bus_events, 0);

    run(0, 8, "R2 R4 R5 full device 0");
    run(11, 3, "R2 mid-region device 1");
    run(5, 10, "R3 spill device 0 to 1");
    run(2, 30, "R3 four devices");
    run(28, 20, "R7 clipped at last device");

    ev0 = bus_events;
    run(40, 4, "R7 start beyond last device");
    chk(bus_events == ev0, "R7 no strobes beyond devices", bus_events - ev0, 0);

    ev0 = bus_events;
    run(9, 0, "R10 zero length");
    chk(bus_events == ev0, "R10 zero length no strobes", bus_events - ev0, 0);

    // device 2 held busy
    dev_ready_i = 4'b1011;
    plan_req(16, 2, total);
    ev0 = bus_events;
    launch(16, 2);
    repeat (30) @(negedge clk_i);
    chk(bus_events == ev0, "R6 wait for ready", bus_events - ev0, 0);
    dev_ready_i = 4'hF;
    finish_req(total, "R6 after ready");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule